// File: doc/BRIEF.md
# Latching Port Change Detector with Deferred Interrupt

This block watches a small set of input ports inside an 8-bit port group and reports any change of level since the last serial access. A snapshot register holds the port levels taken at the most recent access. The live levels are compared with the snapshot on every clock. A mismatch on a monitored port sets a sticky flag for that port and pulls an active-low interrupt line low. Because the flags are sticky, a glitch that reverts before the next access is still reported.

The serial engine in front of the block supplies single-cycle event pulses. One pulse marks the acknowledge of a read or write address for the group. Another marks the acknowledge that starts each further port/flag byte pair of a long read. A level shows that a read is in progress, and a pulse marks the STOP condition. Each acknowledge pulse resamples the snapshot, clears the live flags and releases the interrupt. The flags that had built up are kept in a transmit register, so they can be sent as the flag byte. While a read is in progress, a new change does not pull the interrupt low. The change is held pending and raises the interrupt at STOP, unless a later resample within the same read has already carried the changed data to the host.

Top module: `port_change_irq`

## Requirements
- R1: Outside a read, a level on a monitored input that differs from the snapshot sets that input's live flag and drives irq_no low after the next clock edge.
- R2: The live flags and the interrupt stay latched after the input returns to its snapshot level, until the next resample.
- R3: On an addr_ack_i pulse, snap_o takes port_i, the live flags clear and irq_no is high after that edge.
- R4: On every resample, flags_o is loaded with the live flags OR-ed with any mismatch present in that same cycle. The flag of input k sits at bit IN_LSB+k (bits 2 to 5 by default). All other bits of flags_o read 0.
- R5: A pair_ack_i pulse resamples the snapshot and moves the flags into flags_o exactly as R3 and R4 describe.
- R6: While rd_busy_i is high, a change leaves irq_no high. The change is held pending, and a stop_i pulse then drives irq_no low, even if the input has already reverted.
- R7: If a resample follows a change inside a read, the pending state is dropped and the next stop_i leaves irq_no high.
- R8: After power-on reset, irq_no is high and flags_o is 0. snap_o takes port_i at the first clock edge, and this sets no flag and raises no interrupt.
- R9: Inputs whose in_en_i bit is 0, and port_i bits outside the monitored slice, never set a flag or the interrupt.
- R10: A stop_i pulse with nothing pending leaves irq_no unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| port_i | input | BYTE_W | Synchronised port levels of the whole group byte |
| in_en_i | input | NUM_IN | Per-input monitor enable (input is used as an input) |
| addr_ack_i | input | 1 | Pulse: acknowledge of a group read or write address |
| pair_ack_i | input | 1 | Pulse: acknowledge that starts a new port/flag pair in a long read |
| rd_busy_i | input | 1 | High while a read from the group is in progress |
| stop_i | input | 1 | Pulse: STOP condition seen on the bus |
| flags_o | output | BYTE_W | Flag byte to be transmitted, flags at their port bit positions |
| snap_o | output | BYTE_W | Snapshot byte taken at the last resample |
| irq_no | output | 1 | Active-low latched interrupt |

## Verification
The bench uses the default parameters: a byte of 8 bits with 4 monitored inputs at bits 2 to 5. With this small configuration, all 16 enable masks can be swept against all 16 glitch patterns. Half of the patterns also toggle the four unmonitored bits, so masking and bit placement are checked for every combination. Directed sequences then cover the read-time cases: an interrupt deferred to STOP, suppression after a mid-read resample, a change that lands in the same cycle as the acknowledge, and STOP with nothing pending.

// File: rtl/pci_pkg.sv
package pci_pkg;
  typedef struct packed {
    logic sample;
    logic busy;
    logic stop;
  } pci_evt_t;

  function automatic pci_evt_t pci_evt(input logic addr_ack, input logic pair_ack,
                                       input logic busy, input logic stop);
    pci_evt_t e;
    e.sample = addr_ack | pair_ack;
    e.busy   = busy;
    e.stop   = stop;
    return e;
  endfunction
endpackage

// File: rtl/pci_snap.sv
module pci_snap #(
  parameter int BYTE_W = 8,
  parameter int NUM_IN = 4,
  parameter int IN_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] port_i,
  input  logic [NUM_IN-1:0] in_en_i,
  input  logic              sample_i,
  output logic [BYTE_W-1:0] snap_o,
  output logic [NUM_IN-1:0] diff_o
);
  logic              armed_q;
  logic [BYTE_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      armed_q <= 1'b1;
      // first edge after reset loads the live levels silently
      if (sample_i || !armed_q) snap_q <= port_i;
    end
  end

  always_comb begin
    diff_o = '0;
    if (armed_q) diff_o = in_en_i & (port_i[IN_LSB +: NUM_IN] ^ snap_q[IN_LSB +: NUM_IN]);
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/pci_flags.sv
module pci_flags #(
  parameter int BYTE_W = 8,
  parameter int NUM_IN = 4,
  parameter int IN_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] diff_i,
  input  logic              sample_i,
  output logic [BYTE_W-1:0] flags_o
);
  logic [NUM_IN-1:0] live_q;
  logic [NUM_IN-1:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      tx_q   <= '0;
    end else if (sample_i) begin
      // mismatch seen in the clearing cycle is folded into the sent byte
      tx_q   <= live_q | diff_i;
      live_q <= '0;
    end else begin
      live_q <= live_q | diff_i;
    end
  end

  for (genvar b = 0; b < BYTE_W; b++) begin : g_pos
    if (b >= IN_LSB && b < IN_LSB + NUM_IN) begin : g_in
      assign flags_o[b] = tx_q[b-IN_LSB];
    end else begin : g_out
      assign flags_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/pci_irq.sv
module pci_irq #(
  parameter int NUM_IN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] diff_i,
  input  pci_pkg::pci_evt_t evt_i,
  output logic              irq_no
);
  logic irq_q, pend_q, hit;

  assign hit = |diff_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (evt_i.sample) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (evt_i.stop) begin
      if (pend_q || hit) irq_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (hit) begin
      if (evt_i.busy) pend_q <= 1'b1;
      else            irq_q  <= 1'b1;
    end
  end

  assign irq_no = ~irq_q;
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int BYTE_W = 8,
  parameter int NUM_IN = 4,
  parameter int IN_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] port_i,
  input  logic [NUM_IN-1:0] in_en_i,
  input  logic              addr_ack_i,
  input  logic              pair_ack_i,
  input  logic              rd_busy_i,
  input  logic              stop_i,
  output logic [BYTE_W-1:0] flags_o,
  output logic [BYTE_W-1:0] snap_o,
  output logic              irq_no
);
  pci_pkg::pci_evt_t evt;
  logic [NUM_IN-1:0] diff;

  assign evt = pci_pkg::pci_evt(addr_ack_i, pair_ack_i, rd_busy_i, stop_i);

  pci_snap #(.BYTE_W(BYTE_W), .NUM_IN(NUM_IN), .IN_LSB(IN_LSB)) u_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .port_i   (port_i),
    .in_en_i  (in_en_i),
    .sample_i (evt.sample),
    .snap_o   (snap_o),
    .diff_o   (diff)
  );

  pci_flags #(.BYTE_W(BYTE_W), .NUM_IN(NUM_IN), .IN_LSB(IN_LSB)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .diff_i   (diff),
    .sample_i (evt.sample),
    .flags_o  (flags_o)
  );

  pci_irq #(.NUM_IN(NUM_IN)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .diff_i (diff),
    .evt_i  (evt),
    .irq_no (irq_no)
  );
endmodule

// File: rtl/pci_chk.sv
module pci_chk #(
  parameter int BYTE_W = 8,
  parameter int NUM_IN = 4,
  parameter int IN_LSB = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] port_i,
  input logic [NUM_IN-1:0] in_en_i,
  input logic              addr_ack_i,
  input logic              pair_ack_i,
  input logic              rd_busy_i,
  input logic              stop_i,
  input logic [BYTE_W-1:0] flags_o,
  input logic [BYTE_W-1:0] snap_o,
  input logic              irq_no
);
  localparam logic [BYTE_W-1:0] IN_MASK = BYTE_W'(((1 << NUM_IN) - 1) << IN_LSB);

  logic seen_q;
  logic mism;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign mism = |(in_en_i & (port_i[IN_LSB +: NUM_IN] ^ snap_o[IN_LSB +: NUM_IN]));

  assert_release_on_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ack_i |=> irq_no);

  assert_snap_on_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ack_i |=> snap_o == $past(port_i));

  assert_snap_on_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ack_i |=> snap_o == $past(port_i));

  assert_hold_in_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_busy_i && !stop_i && irq_no) |=> irq_no);

  assert_change_fires_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && mism && !rd_busy_i && !addr_ack_i && !pair_ack_i) |=> !irq_no);

  assert_unused_bits_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o & ~IN_MASK) == '0);
endmodule

bind port_change_irq pci_chk #(.BYTE_W(BYTE_W), .NUM_IN(NUM_IN), .IN_LSB(IN_LSB)) u_chk (.*);

// File: tb/sim_port_change_irq.sv
`timescale 1ns/1ps
module sim_port_change_irq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] port = 8'hFF;
  logic [3:0] en = 4'hF;
  logic       addr_ack = 1'b0, pair_ack = 1'b0, busy = 1'b0, stop = 1'b0;
  logic [7:0] flags, snap;
  logic       irq_n;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  port_change_irq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .port_i(port), .in_en_i(en),
    .addr_ack_i(addr_ack), .pair_ack_i(pair_ack), .rd_busy_i(busy), .stop_i(stop),
    .flags_o(flags), .snap_o(snap), .irq_no(irq_n)
  );

  function automatic logic [7:0] spread(input logic [3:0] v);
    return {2'b00, v, 2'b00};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ack();
    addr_ack = 1'b1; step(); addr_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #20;
    @(negedge clk) rst_ni = 1'b1;
    step();
    chk("R8 irq after reset", {7'd0, irq_n}, 8'd1);
    chk("R8 flags after reset", flags, 8'h00);
    chk("R8 snapshot load", snap, 8'hFF);
    step();
    chk("R8 no irq from load", {7'd0, irq_n}, 8'd1);

    // sweep: enable masks x glitch patterns, some with unmonitored bits toggled
    for (int m = 0; m < 16; m++) begin
      for (int t = 0; t < 16; t++) begin
        logic [7:0] p0, g;
        logic [3:0] hitm;
        p0 = 8'(m * 17 + t * 5);
        g  = spread(4'(t)) | ((t % 2 == 1) ? 8'hC3 : 8'h00);
        hitm = 4'(t) & 4'(m);
        en = 4'(m); port = p0;
        ack(); step();
        port = p0 ^ g; step();
        chk("R1/R9 irq on glitch", {7'd0, irq_n}, {7'd0, hitm == 4'd0});
        port = p0; step();
        chk("R2 irq latched", {7'd0, irq_n}, {7'd0, hitm == 4'd0});
        ack();
        chk("R4/R9 flag byte", flags, spread(hitm));
        chk("R3 irq released", {7'd0, irq_n}, 8'd1);
        chk("R3 snapshot", snap, p0);
      end
    end

    // R6: change during read deferred to STOP
    en = 4'hF; port = 8'h00;
    busy = 1'b1; ack();
    port = 8'h04; step();
    chk("R6 no irq in read", {7'd0, irq_n}, 8'd1);
    port = 8'h00; step();
    chk("R6 still high in read", {7'd0, irq_n}, 8'd1);
    busy = 1'b0; stop = 1'b1; step(); stop = 1'b0;
    chk("R6 irq at stop", {7'd0, irq_n}, 8'd0);
    ack();
    chk("R3 release after read", {7'd0, irq_n}, 8'd1);
    chk("R4 flag from read", flags, 8'h04);

    // R7: change carried out by a pair resample before STOP
    busy = 1'b1; ack();
    port = 8'h08; step();
    pair_ack = 1'b1; step(); pair_ack = 1'b0;
    chk("R5 pair flag byte", flags, 8'h08);
    chk("R5 pair snapshot", snap, 8'h08);
    busy = 1'b0; stop = 1'b1; step(); stop = 1'b0;
    chk("R7 suppressed at stop", {7'd0, irq_n}, 8'd1);

    // R4: change in the same cycle as the acknowledge
    port = 8'h28; addr_ack = 1'b1; step(); addr_ack = 1'b0;
    chk("R4 same-cycle flag", flags, 8'h20);
    chk("R4 same-cycle snapshot", snap, 8'h28);
    step();
    chk("R4 same-cycle no irq", {7'd0, irq_n}, 8'd1);

    // R10: stop with nothing pending
    stop = 1'b1; step(); stop = 1'b0;
    chk("R10 stop idle high", {7'd0, irq_n}, 8'd1);
    port = 8'h2C; step();
    chk("R1 irq low", {7'd0, irq_n}, 8'd0);
    port = 8'h28;
    stop = 1'b1; step(); stop = 1'b0;
    chk("R10 stop keeps low", {7'd0, irq_n}, 8'd0);
    ack();
    chk("R3 final release", {7'd0, irq_n}, 8'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule